// File: doc/BRIEF.md
# Crest factor overcurrent detector

This block guards a half-bridge against inductor saturation and capacitive-mode operation. It judges the shape of the low-side switch current, not its absolute size. A sensing front end delivers current magnitudes as digital samples taken while the low-side switch conducts. A strobe marks the end of each switching cycle. The block keeps two values: the largest sample seen since the last strobe, and a running average of all samples. At each strobe it compares that cycle's peak against a fixed multiple (5.5) of the average. Both values pass through the same unknown on-resistance, so its spread and temperature drift cancel out of the ratio.

The surrounding controller raises the arm input only while the lamp runs in its regulated dimming state. The input stays low during preheat and ignition, and while it is low all tracking state is held cleared. After arming, a programmable number of cycle strobes is ignored while the average builds up. A detected fault sets an output that stays set until reset, and the controller uses it to shut the half-bridge down.

Top module: `crest_guard`

## Requirements
- R1: After reset `trip_o` is 0, and asserting `rst_n` low is the only way to return a set `trip_o` to 0.
- R2: The peak judged at a strobe is the largest sample accepted since the previous strobe (or since arming), including a sample valid in the strobe cycle itself. The peak returns to 0 after every strobe, so a spike never counts toward a later cycle.
- R3: The average state A starts at 0 when the block is armed. On each armed clock with `smp_vld_i` high it becomes A - floor(A/2^K) + sample, where K is the averaging shift (default 4). The average current is A/2^K, and A never exceeds (2^W-1)*2^K.
- R4: At an armed strobe after blanking, a fault is detected when 2*peak*2^K > 11*A. Here A is the average state before that clock's own sample is added. This is the peak exceeding 5.5 times the average.
- R5: `trip_o` rises on the clock edge that ends the strobe cycle in which the fault is detected, and at no other edge.
- R6: While `arm_i` is 0, no fault is detected, samples and strobes have no effect, and peak, average and blanking state are cleared.
- R7: After arming, the first `blank_len_i` strobes can never set `trip_o`. With `blank_len_i` = 0 the first strobe may already trip.
- R8: Once set, `trip_o` stays 1 whatever the arm, sample and strobe inputs do.
- R9: A peak that equals exactly 5.5 times the average (2*peak*2^K == 11*A) does not trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also clears the latched fault |
| arm_i | input | 1 | High while the controller is in the regulated dimming state |
| blank_len_i | input | BW (8) | Number of strobes ignored after arming |
| smp_vld_i | input | 1 | Current sample valid |
| smp_mag_i | input | W (12) | Current sample magnitude, unsigned |
| cyc_end_i | input | 1 | Switching-cycle boundary strobe |
| trip_o | output | 1 | Sticky crest-factor fault |

## Verification
The assertions check several properties on every cycle. The fault stays latched once set. A rise of the fault comes only from an armed strobe whose blanking has ended. The average state never leaves its bound, and the peak holder never loses a value inside a cycle. The bench scenarios are needed for the numeric behaviour. That covers the exact 11-to-2 threshold with the equal case not tripping, and the peak being cleared at strobes while a spike on the strobe cycle still counts. It also covers the restart of all state after a disarm and the number of strobes that blanking hides.

// File: rtl/crest_pkg.sv
package crest_pkg;

   typedef enum logic [0:0] {
      CMP_SHIFT_ADD = 1'b0,
      CMP_MULTIPLY  = 1'b1
   } cmp_style_e;

   // Picks the cheapest comparator form for a given ratio.
   function automatic cmp_style_e pick_style(input int num, input int den);
      if (num == 11 && den == 2) return CMP_SHIFT_ADD;
      return CMP_MULTIPLY;
   endfunction

   // Bits needed to hold num*acc or den*peak*2^k without loss.
   function automatic int cmp_width(input int acc_w, input int num, input int den);
      return acc_w + $clog2(num + 1) + $clog2(den + 1);
   endfunction

endpackage

// File: rtl/crest_peak.sv
module crest_peak #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         smp_vld_i,
   input  logic [W-1:0] smp_i,
   input  logic         cyc_end_i,
   output logic [W-1:0] cyc_pk_o
);

   generate
      if (W < 2) begin : g_bad_w
         $error("crest_peak: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] pk_q;

   // Peak of the current cycle, with this clock's sample folded in.
   assign cyc_pk_o = (smp_vld_i && (smp_i > pk_q)) ? smp_i : pk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pk_q <= '0;
      end else if (clr_i || cyc_end_i) begin
         pk_q <= '0;
      end else begin
         pk_q <= cyc_pk_o;
      end
   end

   AST_PEAK_KEEPS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && smp_vld_i && !cyc_end_i) |=> (pk_q >= $past(smp_i))); // R2

   AST_PEAK_NO_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !cyc_end_i) |=> (pk_q >= $past(pk_q))); // R2

endmodule

// File: rtl/crest_ema.sv
module crest_ema #(
   parameter int W  = 12,
   parameter int K  = 4,
   localparam int AW = W + K
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          smp_vld_i,
   input  logic [W-1:0]  smp_i,
   output logic [AW-1:0] acc_o
);

   generate
      if (K < 1 || K > 12) begin : g_bad_k
         $error("crest_ema: K must lie in 1..12");
      end
   endgenerate

   localparam logic [AW-1:0] ACC_MAX = {{W{1'b1}}, {K{1'b0}}};

   logic [AW-1:0] acc_q;
   logic [AW-1:0] acc_n;

   // Leaky integrator: drop 1/2^K of the state, add the new sample.
   assign acc_n = acc_q - (acc_q >> K) + AW'(smp_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clr_i) begin
         acc_q <= '0;
      end else if (smp_vld_i) begin
         acc_q <= acc_n;
      end
   end

   assign acc_o = acc_q;

   AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q <= ACC_MAX); // R3

endmodule

// File: rtl/crest_blank.sv
module crest_blank #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          cyc_end_i,
   input  logic [BW-1:0] len_i,
   output logic          done_o
);

   generate
      if (BW < 1 || BW > 24) begin : g_bad_bw
         $error("crest_blank: BW must lie in 1..24");
      end
   endgenerate

   logic [BW-1:0] cnt_q;

   assign done_o = (cnt_q >= len_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (cyc_end_i && !done_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_BLANK_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && cyc_end_i && !done_o) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R7

endmodule

// File: rtl/crest_ratio_cmp.sv
module crest_ratio_cmp
   import crest_pkg::*;
#(
   parameter int W   = 12,
   parameter int K   = 4,
   parameter int NUM = 11,
   parameter int DEN = 2,
   localparam int AW = W + K,
   localparam int CW = cmp_width(AW, NUM, DEN)
) (
   input  logic [W-1:0]  pk_i,
   input  logic [AW-1:0] acc_i,
   output logic          over_o
);

   localparam cmp_style_e STYLE = pick_style(NUM, DEN);

   generate
      if (NUM <= DEN || DEN < 1) begin : g_bad_ratio
         $error("crest_ratio_cmp: ratio NUM/DEN must exceed one");
      end
   endgenerate

   logic [CW-1:0] pk_x;
   logic [CW-1:0] acc_x;
   logic [CW-1:0] lhs;
   logic [CW-1:0] rhs;

   assign pk_x  = CW'(pk_i);
   assign acc_x = CW'(acc_i);

   generate
      if (STYLE == CMP_SHIFT_ADD) begin : g_shift_add
         // 2*peak*2^K against 8A + 2A + A.
         assign lhs = pk_x << (K + 1);
         assign rhs = (acc_x << 3) + (acc_x << 1) + acc_x;
      end else begin : g_multiply
         assign lhs = (pk_x * CW'(DEN)) << K;
         assign rhs = acc_x * CW'(NUM);
      end
   endgenerate

   // Strict: the equal case is not a fault.
   assign over_o = (lhs > rhs);

endmodule

// File: rtl/crest_guard.sv
module crest_guard
   import crest_pkg::*;
#(
   parameter int W   = 12,
   parameter int K   = 4,
   parameter int BW  = 8,
   parameter int NUM = 11,
   parameter int DEN = 2,
   localparam int AW = W + K
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm_i,
   input  logic [BW-1:0] blank_len_i,
   input  logic          smp_vld_i,
   input  logic [W-1:0]  smp_mag_i,
   input  logic          cyc_end_i,
   output logic          trip_o
);

   logic          clr;
   logic [W-1:0]  cyc_pk;
   logic [AW-1:0] acc;
   logic          blank_done;
   logic          over;
   logic          trip_q;

   assign clr = !arm_i;

   crest_peak #(.W(W)) peak_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .smp_vld_i (smp_vld_i),
      .smp_i     (smp_mag_i),
      .cyc_end_i (cyc_end_i),
      .cyc_pk_o  (cyc_pk)
   );

   crest_ema #(.W(W), .K(K)) ema_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .smp_vld_i (smp_vld_i),
      .smp_i     (smp_mag_i),
      .acc_o     (acc)
   );

   crest_blank #(.BW(BW)) blank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .cyc_end_i (cyc_end_i),
      .len_i     (blank_len_i),
      .done_o    (blank_done)
   );

   crest_ratio_cmp #(.W(W), .K(K), .NUM(NUM), .DEN(DEN)) cmp_i (
      .pk_i   (cyc_pk),
      .acc_i  (acc),
      .over_o (over)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trip_q <= 1'b0;
      end else if (arm_i && cyc_end_i && blank_done && over) begin
         trip_q <= 1'b1;
      end
   end

   assign trip_o = trip_q;

   AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(trip_o) |-> trip_o); // R8

   AST_TRIP_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trip_o) |-> $past(arm_i)); // R6

   AST_TRIP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trip_o) |-> $past(cyc_end_i)); // R5

   AST_TRIP_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trip_o) |-> $past(blank_done)); // R7

endmodule

// File: tb/crest_guard_tb.sv
module crest_guard_tb_top;

   localparam int W  = 12;
   localparam int K  = 4;
   localparam int BW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm_i = 1'b0;
   logic [BW-1:0] blank_len_i = '0;
   logic          smp_vld_i = 1'b0;
   logic [W-1:0]  smp_mag_i = '0;
   logic          cyc_end_i = 1'b0;
   logic          trip_o;

   int checks = 0;
   int failures = 0;

   // Reference state, built from the requirements.
   longint m_acc = 0;
   int     m_pk  = 0;
   int     m_blk = 0;
   int     m_len = 0;
   bit     m_trip = 1'b0;

   always #2 clk = ~clk;

   crest_guard dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm_i       (arm_i),
      .blank_len_i (blank_len_i),
      .smp_vld_i   (smp_vld_i),
      .smp_mag_i   (smp_mag_i),
      .cyc_end_i   (cyc_end_i),
      .trip_o      (trip_o)
   );

   // R4 / R9: strict 2*peak*2^K > 11*A.
   function automatic bit exceeds(input int pk, input longint acc);
      return (longint'(pk) * 2 * (64'd1 << K)) > (acc * 11);
   endfunction

   // R3: leaky-average update.
   function automatic longint ema_next(input longint acc, input int s);
      return acc - (acc >> K) + s;
   endfunction

   task automatic check(input bit act, input bit exp, input string req);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s trip_o actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      int cpk;
      cpk = 0;
      @(negedge clk);
      rst_n = 1'b0; arm_i = 1'b0; smp_vld_i = 1'b0; cyc_end_i = 1'b0; smp_mag_i = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_acc = 0; m_pk = cpk; m_blk = 0; m_trip = 1'b0;
      check(trip_o, 1'b0, "R1");
   endtask

   task automatic step(input bit arm, input bit vld, input int mag, input bit e, input string req);
      int cpk;
      @(negedge clk);
      arm_i = arm; smp_vld_i = vld; smp_mag_i = W'(mag); cyc_end_i = e;
      blank_len_i = BW'(m_len);
      @(posedge clk);
      if (!arm) begin
         m_acc = 0; m_pk = 0; m_blk = 0;
      end else begin
         cpk = (vld && mag > m_pk) ? mag : m_pk;
         if (e) begin
            if (m_blk >= m_len && exceeds(cpk, m_acc)) m_trip = 1'b1;
            if (m_blk < m_len) m_blk++;
            m_pk = 0;
         end else begin
            m_pk = cpk;
         end
         if (vld) m_acc = ema_next(m_acc, mag);
      end
      #1;
      check(trip_o, m_trip, req);
   endtask

   initial begin
      #(4 * 200000);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd5021));

      // R1: reset state.
      do_reset();

      // R7, R9, R4, R2, R5: one blanked strobe, an exact-threshold miss, then a held spike.
      m_len = 1;
      step(1, 1, 32, 1, "R7");   // blanked even though far above threshold
      step(1, 1, 11, 1, "R9");   // 32*11 == 11*32: no trip
      step(1, 1, 12, 1, "R4");   // below threshold
      step(1, 1, 100, 0, "R2");  // spike held within the cycle
      step(1, 0, 0, 1, "R5");    // strobe: trip visible right after this edge

      // R8: sticky whatever the inputs do.
      step(0, 1, 4095, 1, "R8");
      step(1, 0, 0, 0, "R8");
      step(0, 0, 0, 1, "R8");

      // R1: only reset clears it.
      do_reset();

      // R6: disarmed samples and strobes do nothing, and state restarts.
      m_len = 0;
      step(0, 1, 4000, 0, "R6");
      step(0, 1, 4000, 1, "R6");
      step(1, 0, 0, 1, "R6");    // peak cleared by disarm: no trip
      step(1, 1, 5, 1, "R7");    // blank length zero: first real strobe trips

      // R2: a spike on a blanked strobe cycle must not carry into the next cycle.
      do_reset();
      m_len = 1;
      step(1, 1, 900, 1, "R2");
      step(1, 0, 0, 1, "R2");
      step(1, 1, 60, 0, "R3");
      step(1, 1, 60, 1, "R3");

      // Random traffic checked against the reference model.
      for (int s = 0; s < 60; s++) begin
         do_reset();
         m_len = int'($urandom_range(0, 3));
         for (int n = 0; n < 80; n++) begin
            bit arm, vld, e;
            int mag;
            arm = ($urandom_range(0, 99) >= 4);
            vld = ($urandom_range(0, 99) < 70);
            e   = ($urandom_range(0, 3) == 0);
            mag = ($urandom_range(0, 99) < 6) ? int'($urandom_range(0, 4095))
                                              : int'($urandom_range(100, 400));
            step(arm, vld, mag, e, "R4");
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule